// File: doc/BRIEF.md
# I2C Master Receive Control Unit

This block is the register and sequencing front end of an I2C master receiver. Software reaches it through a simple addressed read/write port. A separate bus engine, which drives the serial lines, tells it when the bus is busy, when arbitration was lost, when a NACK came back, when a transfer phase has ended, and when a byte has been received. In return the block issues a one-cycle launch request, a stop request level, the master and start-byte mode levels, the slave address and a running count of bytes still to be received.

Received bytes go into an internal FIFO. Two flags report its state. One rises as soon as the FIFO holds more bytes than a programmed threshold. The other rises at the end of a phase when some bytes remain but not enough to reach that level. Start and stop request bits can be combined in three ways: a whole transfer in one write, a start followed later by a stop, or a chain of repeated starts ending in a stop. The block clears these request bits itself when a phase ends, and it drops master mode when the phase ended with a stop. Event flags are cleared by writing 1. A single interrupt output combines the flags with an enable mask.

Register map (3-bit address): 0 control, 1 status, 2 interrupt enable, 3 receive data, 4 buffer configuration, 5 buffer status, 6 slave address, 7 byte count.

Top module: `i2c_mrx_ctl`

## Requirements
- R1: After reset, control, status, interrupt enable, buffer status, start_o and irq_o all read 0.
- R2: Status bits 0 (arbitration lost), 1 (NACK), 2 (access ready), 3 (receive ready) and 13 (receive drain) are cleared by writing 1 to their position in the status register (address 1). A 0 in the write data leaves the bit unchanged.
- R3: A pulse on arb_lost_i sets status bit 0, a pulse on nack_i sets bit 1, and a pulse on phase_done_i sets bit 2. Status bit 12 always shows bus_busy_i.
- R4: irq_o is high exactly when some status bit and the same bit of the interrupt enable register (address 2) are both 1. After a status clear it is low from the next clock.
- R5: While control bit 15 (enable) is 0, the control register reads 0, no launch is issued, received bytes are discarded and the flags stay 0. Enable and the mode bits may be written together.
- R6: Writing control with bit 15, bit 10 (master) and bit 0 (start) set while the bus is free makes start_o high for exactly one cycle, in the cycle after the write.
- R7: A start request made while bus_busy_i is 1 and no transfer is in progress stays pending with start_o low, and it is launched in the first cycle the bus is free.
- R8: At the end of a phase with bit 1 (stop) clear, bits 0 and 1 are cleared and master mode stays set. A new start written during such a transfer launches even while bus_busy_i is 1.
- R9: At the end of a phase with the stop bit set, bits 0, 1 and 10 are cleared and master_o goes low.
- R10: Status bit 3 sets when the FIFO count exceeds the threshold in buffer configuration bits [13:8] (address 4), that is, when it holds threshold+1 bytes or more.
- R11: Status bit 13 sets at a phase end when the FIFO holds at least one byte but no more than the threshold.
- R12: Each read of address 3 returns the oldest byte in bits [7:0] and removes it. Reading an empty FIFO returns 0 and leaves the count, shown in buffer status bits [13:8] (address 5), at 0.
- R13: On each launch, bytes_left_o is loaded from the byte count register (address 7). It then decreases by one for each received byte and stops at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (pops the FIFO at address 3) |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the addressed register |
| bus_busy_i | input | 1 | Bus engine reports the bus as busy |
| arb_lost_i | input | 1 | Arbitration lost pulse |
| nack_i | input | 1 | NACK received pulse |
| phase_done_i | input | 1 | Transfer phase finished pulse |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | 8 | Received byte |
| irq_o | output | 1 | Interrupt request |
| start_o | output | 1 | One-cycle launch request to the engine |
| stop_req_o | output | 1 | Stop requested for the current phase |
| master_o | output | 1 | Master mode active |
| start_byte_o | output | 1 | Start-byte mode |
| slave_addr_o | output | 10 | Target slave address |
| bytes_left_o | output | 16 | Bytes still to be received |

## Verification
On every cycle the assertions check the launch pulse's single-cycle width, the loss of master mode after a stopped phase, the loading of the byte counter at launch, write-1 clearing of the NACK flag and of all flags together, the setting of the arbitration flag, FIFO bounds and empty reads. Only the bench's scenarios can show the sequencing across writes: a start held while the bus is busy, repeated starts inside a transfer, the drain flag against chosen thresholds, FIFO data order, interrupt masking of the busy bit, and the discarding of everything while the enable bit is 0.

// File: rtl/i2cm_ctl_pkg.sv
package i2cm_ctl_pkg;
  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_STAT  = 3'd1,
    A_IEN   = 3'd2,
    A_DATA  = 3'd3,
    A_BCFG  = 3'd4,
    A_BSTAT = 3'd5,
    A_SADR  = 3'd6,
    A_CNT   = 3'd7
  } reg_addr_e;

  localparam int ST_AL   = 0;
  localparam int ST_NACK = 1;
  localparam int ST_ARDY = 2;
  localparam int ST_RRDY = 3;
  localparam int ST_BB   = 12;
  localparam int ST_RDRN = 13;

  localparam int CT_STT = 0;
  localparam int CT_STP = 1;
  localparam int CT_MST = 10;
  localparam int CT_STB = 11;
  localparam int CT_EN  = 15;

  localparam logic [15:0] CT_MASK  = 16'h8C03;
  localparam logic [15:0] ST_FLAGS = 16'h200F;
endpackage

// File: rtl/i2cm_rx_fifo.sv
module i2cm_rx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] count_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] ptr_nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_push = push_i && !flush_i && (cnt_q != CW'(DEPTH));
  assign do_pop  = pop_i && !flush_i && (cnt_q != '0);

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= ptr_nxt(wp_q);
      if (do_pop)  rp_q <= ptr_nxt(rp_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign data_o  = (cnt_q == '0) ? '0 : mem_q[rp_q];
  assign count_o = cnt_q;

  // R12
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/i2cm_cmd_seq.sv
module i2cm_cmd_seq
  import i2cm_ctl_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_wr_i,
  input  logic [15:0]      wdata_i,
  input  logic             bus_busy_i,
  input  logic             phase_done_i,
  input  logic             rx_byte_i,
  input  logic [CNT_W-1:0] cnt_cfg_i,
  output logic [15:0]      ctrl_o,
  output logic             start_o,
  output logic [CNT_W-1:0] bytes_left_o
);
  logic [15:0]      ctrl_q;
  logic             launched_q, in_xfer_q;
  logic [CNT_W-1:0] left_q;
  logic             en;

  assign en = ctrl_q[CT_EN];

  // a running transfer may issue a repeated start regardless of bus busy
  assign start_o = en && ctrl_q[CT_STT] && ctrl_q[CT_MST] && !launched_q
                   && (!bus_busy_i || in_xfer_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_wr_i) begin
      ctrl_q <= wdata_i[CT_EN] ? (wdata_i & CT_MASK) : '0;
    end else if (phase_done_i && en) begin
      ctrl_q[CT_STT] <= 1'b0;
      ctrl_q[CT_STP] <= 1'b0;
      if (ctrl_q[CT_STP]) ctrl_q[CT_MST] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      launched_q <= 1'b0;
      in_xfer_q  <= 1'b0;
    end else if (!en) begin
      launched_q <= 1'b0;
      in_xfer_q  <= 1'b0;
    end else if (phase_done_i) begin
      launched_q <= 1'b0;
      if (ctrl_q[CT_STP]) in_xfer_q <= 1'b0;
    end else if (start_o) begin
      launched_q <= 1'b1;
      in_xfer_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
    end else if (start_o) begin
      left_q <= cnt_cfg_i;
    end else if (rx_byte_i && en && left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign ctrl_o       = ctrl_q;
  assign bytes_left_o = left_q;

  // R6
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  // R9
  stop_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_done_i && en && ctrl_q[CT_STP] && !ctrl_wr_i) |=> !ctrl_o[CT_MST]);

  // R13
  cnt_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> (bytes_left_o == $past(cnt_cfg_i)));
endmodule

// File: rtl/i2cm_stat.sv
module i2cm_stat
  import i2cm_ctl_pkg::*;
#(
  parameter int THR_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             arb_lost_i,
  input  logic             nack_i,
  input  logic             phase_done_i,
  input  logic             bus_busy_i,
  input  logic [4:0]       clr_i,
  input  logic [THR_W-1:0] fifo_cnt_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic [15:0]      ien_i,
  output logic [15:0]      stat_o,
  output logic             irq_o
);
  localparam int NFLG = 5;
  localparam int F_AL = 0, F_NACK = 1, F_ARDY = 2, F_RRDY = 3, F_RDRN = 4;

  logic [NFLG-1:0] flg_q, set;

  always_comb begin
    set         = '0;
    set[F_AL]   = arb_lost_i;
    set[F_NACK] = nack_i;
    set[F_ARDY] = phase_done_i;
    set[F_RRDY] = fifo_cnt_i > thr_i;
    set[F_RDRN] = phase_done_i && (fifo_cnt_i != '0) && (fifo_cnt_i <= thr_i);
  end

  // new events take priority over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flg_q <= '0;
    else if (!en_i) flg_q <= '0;
    else            flg_q <= set | (flg_q & ~clr_i);
  end

  always_comb begin
    stat_o          = '0;
    stat_o[ST_AL]   = flg_q[F_AL];
    stat_o[ST_NACK] = flg_q[F_NACK];
    stat_o[ST_ARDY] = flg_q[F_ARDY];
    stat_o[ST_RRDY] = flg_q[F_RRDY];
    stat_o[ST_RDRN] = flg_q[F_RDRN];
    stat_o[ST_BB]   = bus_busy_i;
  end

  assign irq_o = |(stat_o & ien_i);

  // R2
  w1c_nack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i[F_NACK] && !nack_i) |=> !stat_o[ST_NACK]);

  // R2
  clear_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&clr_i) && !arb_lost_i && !nack_i && !phase_done_i && fifo_cnt_i <= thr_i)
    |=> ((stat_o & ST_FLAGS) == '0));

  // R3
  al_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_lost_i && en_i) |=> stat_o[ST_AL]);
endmodule

// File: rtl/i2c_mrx_ctl.sv
module i2c_mrx_ctl
  import i2cm_ctl_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  parameter int CNT_W      = 16,
  parameter int SA_W       = 10,
  localparam int THR_W     = 6,
  localparam int FCW       = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       reg_addr_i,
  input  logic             reg_wr_i,
  input  logic             reg_rd_i,
  input  logic [15:0]      reg_wdata_i,
  output logic [15:0]      reg_rdata_o,
  input  logic             bus_busy_i,
  input  logic             arb_lost_i,
  input  logic             nack_i,
  input  logic             phase_done_i,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_data_i,
  output logic             irq_o,
  output logic             start_o,
  output logic             stop_req_o,
  output logic             master_o,
  output logic             start_byte_o,
  output logic [SA_W-1:0]  slave_addr_o,
  output logic [CNT_W-1:0] bytes_left_o
);
  logic [15:0]      ien_q, ctrl, stat;
  logic [THR_W-1:0] thr_q, fcnt6;
  logic [SA_W-1:0]  sadr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [FCW-1:0]   fcnt;
  logic [7:0]       fdata;
  logic             en, wr_ctrl, wr_stat, pop;
  logic [4:0]       clr;
  reg_addr_e        addr;

  assign addr    = reg_addr_e'(reg_addr_i);
  assign wr_ctrl = reg_wr_i && addr == A_CTRL;
  assign wr_stat = reg_wr_i && addr == A_STAT;
  assign pop     = reg_rd_i && addr == A_DATA;
  assign en      = ctrl[CT_EN];
  assign fcnt6   = THR_W'(fcnt);
  assign clr     = wr_stat ? {reg_wdata_i[ST_RDRN], reg_wdata_i[ST_RRDY],
                              reg_wdata_i[ST_ARDY], reg_wdata_i[ST_NACK],
                              reg_wdata_i[ST_AL]} : 5'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q  <= '0;
      thr_q  <= '0;
      sadr_q <= '0;
      cnt_q  <= '0;
    end else if (reg_wr_i) begin
      case (addr)
        A_IEN:   ien_q  <= reg_wdata_i;
        A_BCFG:  thr_q  <= reg_wdata_i[13:8];
        A_SADR:  sadr_q <= reg_wdata_i[SA_W-1:0];
        A_CNT:   cnt_q  <= reg_wdata_i[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  i2cm_cmd_seq #(.CNT_W(CNT_W)) i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_wr_i    (wr_ctrl),
    .wdata_i      (reg_wdata_i),
    .bus_busy_i   (bus_busy_i),
    .phase_done_i (phase_done_i),
    .rx_byte_i    (rx_valid_i),
    .cnt_cfg_i    (cnt_q),
    .ctrl_o       (ctrl),
    .start_o      (start_o),
    .bytes_left_o (bytes_left_o)
  );

  i2cm_rx_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (!en),
    .push_i  (rx_valid_i),
    .data_i  (rx_data_i),
    .pop_i   (pop),
    .data_o  (fdata),
    .count_o (fcnt)
  );

  i2cm_stat #(.THR_W(THR_W)) i_stat (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en),
    .arb_lost_i   (arb_lost_i),
    .nack_i       (nack_i),
    .phase_done_i (phase_done_i),
    .bus_busy_i   (bus_busy_i),
    .clr_i        (clr),
    .fifo_cnt_i   (fcnt6),
    .thr_i        (thr_q),
    .ien_i        (ien_q),
    .stat_o       (stat),
    .irq_o        (irq_o)
  );

  always_comb begin
    case (addr)
      A_CTRL:  reg_rdata_o = ctrl;
      A_STAT:  reg_rdata_o = stat;
      A_IEN:   reg_rdata_o = ien_q;
      A_DATA:  reg_rdata_o = {8'h00, fdata};
      A_BCFG:  reg_rdata_o = {2'b00, thr_q, 8'h00};
      A_BSTAT: reg_rdata_o = {2'b00, fcnt6, 8'h00};
      A_SADR:  reg_rdata_o = 16'(sadr_q);
      default: reg_rdata_o = 16'(cnt_q);
    endcase
  end

  assign stop_req_o   = ctrl[CT_STP];
  assign master_o     = ctrl[CT_MST];
  assign start_byte_o = ctrl[CT_STB];
  assign slave_addr_o = sadr_q;

  // R12
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && fcnt == '0 && !rx_valid_i) |=> (fcnt == '0));
endmodule

// File: tb/test_i2c_mrx_ctl.sv
`timescale 1ns/1ps
module test_i2c_mrx_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] wdata = '0, rdata;
  logic        bb = 1'b0, al = 1'b0, nk = 1'b0, pd = 1'b0, rxv = 1'b0;
  logic [7:0]  rxd = '0;
  logic        irq, start, stop_req, mst, stb;
  logic [9:0]  sa;
  logic [15:0] left;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  i2c_mrx_ctl i_i2c_mrx_ctl (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr),
    .reg_rd_i(rd), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .bus_busy_i(bb), .arb_lost_i(al), .nack_i(nk), .phase_done_i(pd),
    .rx_valid_i(rxv), .rx_data_i(rxd), .irq_o(irq), .start_o(start),
    .stop_req_o(stop_req), .master_o(mst), .start_byte_o(stb),
    .slave_addr_o(sa), .bytes_left_o(left)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0; #1;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0; #1;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); rxv = 1'b1; rxd = b;
    @(negedge clk); rxv = 1'b0; #1;
  endtask

  task automatic ev(input int which);
    @(negedge clk);
    case (which) 0: al = 1'b1; 1: nk = 1'b1; default: pd = 1'b1; endcase
    @(negedge clk); al = 1'b0; nk = 1'b0; pd = 1'b0; #1;
  endtask

  function automatic logic exp_rrdy(input int n, input int thr);
    return n > thr;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog act=timeout exp=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [7:0]  q [8];
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_reg(3'd0, d); chk("R1 ctrl", d, 0);
    rd_reg(3'd1, d); chk("R1 stat", d, 0);
    rd_reg(3'd2, d); chk("R1 ien", d, 0);
    rd_reg(3'd5, d); chk("R1 bufstat", d, 0);
    chk("R1 start/irq", {start, irq}, 0);

    // R5 disabled: nothing takes effect
    wr_reg(3'd0, 16'h0403);
    chk("R5 no launch", start, 0);
    rd_reg(3'd0, d); chk("R5 ctrl", d, 0);
    push(8'hAA); ev(1);
    rd_reg(3'd5, d); chk("R5 fifo", d, 0);
    rd_reg(3'd1, d); chk("R5 flags", d, 0);

    // R6 R13 full transfer
    wr_reg(3'd7, 16'd5);
    wr_reg(3'd4, 16'h0300);
    wr_reg(3'd6, 16'h0155);
    chk("R13 slave addr", sa, 10'h155);
    wr_reg(3'd0, 16'h8403);
    chk("R6 start pulse", start, 1);
    @(negedge clk); #1;
    chk("R6 pulse one cycle", start, 0);
    chk("R13 load", left, 5);
    push(8'h11); push(8'h22); push(8'h33);
    chk("R13 decrement", left, 2);
    rd_reg(3'd1, d); chk("R10 below threshold", d[3], 0);
    push(8'h44);
    rd_reg(3'd1, d); chk("R10 at threshold+1", d[3], 1);
    chk("R13 decrement 2", left, 1);
    ev(2);
    rd_reg(3'd0, d); chk("R9 ctrl after stop", d, 16'h8000);
    chk("R9 master low", mst, 0);
    rd_reg(3'd1, d); chk("R3 ardy", d[2], 1);
    chk("R11 no drain when full", d[13], 0);
    rd_reg(3'd3, d); chk("R12 pop0", d, 16'h11);
    rd_reg(3'd3, d); chk("R12 pop1", d, 16'h22);
    rd_reg(3'd3, d); chk("R12 pop2", d, 16'h33);
    rd_reg(3'd3, d); chk("R12 pop3", d, 16'h44);
    rd_reg(3'd3, d); chk("R12 empty read", d, 0);
    rd_reg(3'd5, d); chk("R12 count stays 0", d, 0);

    // R2 write 0 keeps, R4 irq
    wr_reg(3'd1, 16'h0000);
    rd_reg(3'd1, d); chk("R2 zero write keeps", d, 16'h000C);
    wr_reg(3'd2, 16'h200F);
    chk("R4 irq on", irq, 1);
    wr_reg(3'd1, 16'h0004);
    rd_reg(3'd1, d); chk("R2 clear ardy only", d, 16'h0008);
    wr_reg(3'd1, 16'h200F);
    chk("R4 irq off next clock", irq, 0);
    bb = 1'b1; #1;
    chk("R4 busy masked", irq, 0);
    rd_reg(3'd1, d); chk("R3 busy bit", d, 16'h1000);

    // R3 event flags
    ev(0); ev(1);
    rd_reg(3'd1, d); chk("R3 al nack", d, 16'h1003);
    chk("R4 irq events", irq, 1);
    wr_reg(3'd1, 16'h0003);

    // R7 pending start while busy
    wr_reg(3'd0, 16'h8401);
    chk("R7 held", start, 0);
    repeat (3) @(negedge clk);
    #1 chk("R7 still held", start, 0);
    bb = 1'b0; #1;
    chk("R7 launch when free", start, 1);
    @(negedge clk); #1;
    chk("R7 single pulse", start, 0);
    ev(2);
    rd_reg(3'd0, d); chk("R8 phase end keeps master", d, 16'h8400);
    bb = 1'b1;
    wr_reg(3'd0, 16'h8401);
    chk("R8 repeated start while busy", start, 1);
    wr_reg(3'd0, 16'h8402);
    chk("R8 stop only no launch", start, 0);
    chk("R8 stop level", stop_req, 1);
    ev(2);
    rd_reg(3'd0, d); chk("R9 after stop", d, 16'h8000);
    bb = 1'b0;
    wr_reg(3'd1, 16'h200F);

    // R11 drain
    push(8'h5A); push(8'hA5);
    ev(2);
    rd_reg(3'd1, d); chk("R11 drain", d[13], 1);
    chk("R10 not ready", d[3], 0);
    rd_reg(3'd3, d); chk("R12 drain pop0", d, 16'h5A);
    rd_reg(3'd3, d); chk("R12 drain pop1", d, 16'hA5);
    wr_reg(3'd1, 16'h200F);

    // random FIFO / threshold runs
    for (int it = 0; it < 24; it++) begin
      int n, thr;
      thr = int'($urandom_range(0, 7));
      n   = int'($urandom_range(0, 8));
      wr_reg(3'd4, 16'(thr << 8));
      for (int k = 0; k < n; k++) begin
        q[k] = 8'($urandom);
        push(q[k]);
      end
      rd_reg(3'd5, d); chk("R12 count", d, 16'(n << 8));
      rd_reg(3'd1, d); chk("R10 ready flag", d[3], exp_rrdy(n, thr));
      for (int k = 0; k < n; k++) begin
        rd_reg(3'd3, d); chk("R12 order", d, 16'(q[k]));
      end
      wr_reg(3'd1, 16'h200F);
      rd_reg(3'd1, d); chk("R2 clear", d, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule